// File: doc/BRIEF.md
# USB Device Event Status and Interrupt Register

This block sits between a USB device protocol engine and the processor. The engine reports six kinds of bus event as single-cycle pulses: suspend, start-of-frame, bus reset, wake-up, setup packet received, and set-configuration completed. The set-configuration pulse carries the configuration value with it. Each pulse sets a sticky flag in a status register. Software reads the flags and clears them over a small register bus.

Five of the flags are interrupt causes. A second register holds one enable per cause, and the block drives one interrupt line from the enabled causes. Flags are cleared by writing 0. Writing 1 has no effect. The bus marks reads that belong to a read-modify-write. Such a read returns 1 in every cause bit, so the write that follows cannot clear a cause that software did not mean to clear. The most recent configuration value is held in a read-only field of the enable register and is also driven out as a port.

Top module: `usbev_status_top`

## Requirements
- R1: An event pulse sets its flag in the status register (address 0) on the next clock edge. Bit positions: suspend 5, start-of-frame 4, bus reset 3, wake-up 2, setup 1, configured 0.
- R2: A write to the status register clears each flag whose data bit is 0 and leaves unchanged each flag whose data bit is 1. A write of 1 never sets a flag.
- R3: If an event pulse and a write that would clear the same flag arrive in the same cycle, the flag is set after that edge.
- R4: A plain read of address 0 returns the flags in bits 5..0 and 0 in all higher bits. A read with the read-modify-write mark returns 1 in bits 5, 4, 3, 2 and 0, and the true setup flag in bit 1. Writing that value back changes no flag.
- R5: The enable register (address 1) stores write-data bits 5, 4, 3, 2 and 0 as enables for the cause with the same bit position. Bit 1 and all other bits without a function read as 0.
- R6: `irq` is high exactly when some cause flag and its enable are both 1. The setup flag never drives `irq`.
- R7: A set-configuration pulse captures its configuration value into a field that is read at bits [8 +: CFG_W] of the enable register and driven on `cfg_num`. Bus writes do not change this field.
- R8: A synchronous active-high reset clears all flags, all enables and the configuration field, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_suspend | input | 1 | Suspend detected pulse |
| ev_sof | input | 1 | Start-of-frame received pulse |
| ev_bus_reset | input | 1 | Bus reset detected pulse |
| ev_wakeup | input | 1 | Wake-up detected pulse |
| ev_setup | input | 1 | Setup packet received pulse |
| ev_config | input | 1 | Set-configuration completed pulse |
| ev_config_val | input | CFG_W | Configuration value sent with `ev_config` |
| reg_sel | input | 1 | Register access valid this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_rmw | input | 1 | Read belongs to a read-modify-write |
| reg_addr | input | 1 | 0 = status register, 1 = enable register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid during a read cycle, 0 otherwise |
| irq | output | 1 | Combined interrupt request |
| cfg_num | output | CFG_W | Last captured configuration value |

## Verification
The bench drives each event alone and then reads the flags, which shows that every event lands on its own bit. Status writes with all-ones, all-zeros and mixed patterns separate clearing by writing 0 from setting by writing 1. Events that coincide with a clearing write on the same bit show that the event wins. Plain reads and read-modify-write reads of the same flag state show how the mark changes the cause bits while the setup bit keeps its true value. An enable sweep that raises one cause at a time, plus a setup flag with every enable set, tells the masking of each cause apart from a setup flag that must never raise the interrupt.

// File: rtl/usbev_pkg.sv
package usbev_pkg;

    localparam int BUS_W     = 16;
    localparam int NUM_FLAGS = 6;

    // flag bit positions (software decodes these)
    localparam int FLG_SUSPEND = 5;
    localparam int FLG_SOF     = 4;
    localparam int FLG_BUSRST  = 3;
    localparam int FLG_WAKEUP  = 2;
    localparam int FLG_SETUP   = 1;
    localparam int FLG_CONFIG  = 0;

    // bits that are interrupt causes
    localparam logic [NUM_FLAGS-1:0] CAUSE_MASK = 6'b111101;

    typedef enum logic {
        REG_STATUS = 1'b0,
        REG_ENABLE = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic             sel;
        logic             wr;
        logic             rmw;
        reg_sel_e         target;
        logic [BUS_W-1:0] wdata;
    } bus_req_t;

    function automatic logic is_cause(input int idx);
        return CAUSE_MASK[idx];
    endfunction

    // sticky flag: a set event wins over a clear
    function automatic logic flag_next(input logic cur, input logic set, input logic clr);
        return set | (cur & ~clr);
    endfunction

endpackage

// File: rtl/usbev_flag_cell.sv
module usbev_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    import usbev_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) flag_o <= 1'b0;
        else     flag_o <= flag_next(flag_o, set_i, clr_i);
    end

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);                                   // R3
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);                      // R2
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!clr_i && !set_i) |=> $stable(flag_o));             // R2

endmodule

// File: rtl/usbev_status_bank.sv
module usbev_status_bank
    import usbev_pkg::*;
#(
    parameter int N = NUM_FLAGS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] events_i,
    input  logic         wr_i,
    input  logic [N-1:0] wdata_i,
    output logic [N-1:0] flags_o
);
    // a 0 in the write data clears; a 1 leaves the flag alone
    logic [N-1:0] clr;

    always_comb begin
        clr = wr_i ? ~wdata_i : '0;
    end

    for (genvar k = 0; k < N; k++) begin : g_flag
        usbev_flag_cell u_cell (
            .clk    (clk),
            .rst    (rst),
            .set_i  (events_i[k]),
            .clr_i  (clr[k]),
            .flag_o (flags_o[k])
        );
    end

    AST_NO_SET_BY_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_i && (events_i == '0)) |=> ((flags_o & ~$past(flags_o)) == '0));  // R2

endmodule

// File: rtl/usbev_enable_bank.sv
module usbev_enable_bank
    import usbev_pkg::*;
#(
    parameter int N     = NUM_FLAGS,
    parameter int CFG_W = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [N-1:0]     wdata_i,
    input  logic             cfg_evt_i,
    input  logic [CFG_W-1:0] cfg_val_i,
    output logic [N-1:0]     enables_o,
    output logic [CFG_W-1:0] cfg_o
);
    logic [N-1:0] en_q;

    for (genvar k = 0; k < N; k++) begin : g_en
        if (is_cause(k)) begin : g_cause
            always_ff @(posedge clk) begin
                if (rst)       en_q[k] <= 1'b0;
                else if (wr_i) en_q[k] <= wdata_i[k];
            end
        end else begin : g_none
            assign en_q[k] = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)            cfg_o <= '0;
        else if (cfg_evt_i) cfg_o <= cfg_val_i;
    end

    assign enables_o = en_q;

    AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(enables_o));                       // R5
    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !cfg_evt_i |=> $stable(cfg_o));                      // R7
    AST_CFG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        cfg_evt_i |=> (cfg_o == $past(cfg_val_i)));          // R7

endmodule

// File: rtl/usbev_readmux.sv
module usbev_readmux
    import usbev_pkg::*;
#(
    parameter int N       = NUM_FLAGS,
    parameter int CFG_W   = 1,
    parameter int CFG_LSB = 8
) (
    input  bus_req_t         req_i,
    input  logic [N-1:0]     flags_i,
    input  logic [N-1:0]     enables_i,
    input  logic [CFG_W-1:0] cfg_i,
    output logic [BUS_W-1:0] rdata_o
);
    localparam logic [N-1:0] CMASK = CAUSE_MASK[N-1:0];

    always_comb begin
        rdata_o = '0;
        if (req_i.sel && !req_i.wr) begin
            unique case (req_i.target)
                REG_STATUS: begin
                    // causes read as 1 during read-modify-write
                    rdata_o[N-1:0] = req_i.rmw ? (flags_i | CMASK) : flags_i;
                end
                REG_ENABLE: begin
                    rdata_o[N-1:0]             = enables_i & CMASK;
                    rdata_o[CFG_LSB +: CFG_W]  = cfg_i;
                end
                default: rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/usbev_status_top.sv
module usbev_status_top
    import usbev_pkg::*;
#(
    parameter int CFG_W   = 1,
    parameter int CFG_LSB = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ev_suspend,
    input  logic             ev_sof,
    input  logic             ev_bus_reset,
    input  logic             ev_wakeup,
    input  logic             ev_setup,
    input  logic             ev_config,
    input  logic [CFG_W-1:0] ev_config_val,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic             reg_rmw,
    input  logic             reg_addr,
    input  logic [15:0]      reg_wdata,
    output logic [15:0]      reg_rdata,
    output logic             irq,
    output logic [CFG_W-1:0] cfg_num
);
    localparam int N = NUM_FLAGS;

    bus_req_t     req;
    logic [N-1:0] events;
    logic [N-1:0] flags;
    logic [N-1:0] enables;
    logic         wr_status;
    logic         wr_enable;
    logic         unused_wdata_hi;

    always_comb begin
        req.sel    = reg_sel;
        req.wr     = reg_wr;
        req.rmw    = reg_rmw;
        req.target = reg_sel_e'(reg_addr);
        req.wdata  = reg_wdata;
    end

    always_comb begin
        events              = '0;
        events[FLG_SUSPEND] = ev_suspend;
        events[FLG_SOF]     = ev_sof;
        events[FLG_BUSRST]  = ev_bus_reset;
        events[FLG_WAKEUP]  = ev_wakeup;
        events[FLG_SETUP]   = ev_setup;
        events[FLG_CONFIG]  = ev_config;
    end

    assign wr_status       = req.sel && req.wr && (req.target == REG_STATUS);
    assign wr_enable       = req.sel && req.wr && (req.target == REG_ENABLE);
    assign unused_wdata_hi = ^req.wdata[BUS_W-1:N];

    usbev_status_bank #(.N(N)) u_status (
        .clk      (clk),
        .rst      (rst),
        .events_i (events),
        .wr_i     (wr_status),
        .wdata_i  (req.wdata[N-1:0]),
        .flags_o  (flags)
    );

    usbev_enable_bank #(.N(N), .CFG_W(CFG_W)) u_enable (
        .clk       (clk),
        .rst       (rst),
        .wr_i      (wr_enable),
        .wdata_i   (req.wdata[N-1:0]),
        .cfg_evt_i (ev_config),
        .cfg_val_i (ev_config_val),
        .enables_o (enables),
        .cfg_o     (cfg_num)
    );

    usbev_readmux #(.N(N), .CFG_W(CFG_W), .CFG_LSB(CFG_LSB)) u_rmux (
        .req_i     (req),
        .flags_i   (flags),
        .enables_i (enables),
        .cfg_i     (cfg_num),
        .rdata_o   (reg_rdata)
    );

    assign irq = |(flags & enables & CAUSE_MASK[N-1:0]);

    AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (!irq && (events == '0) && !(reg_sel && reg_wr)) |=> !irq);           // R6
    AST_SETUP_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (irq && !ev_suspend && !ev_sof && !ev_bus_reset && !ev_wakeup && !ev_config
         && !(reg_sel && reg_wr)) |=> irq);                                    // R6
    AST_RMW_ONES: assert property (@(posedge clk) disable iff (rst)
        (reg_sel && !reg_wr && reg_rmw && !reg_addr)
            |-> ((reg_rdata[N-1:0] & CAUSE_MASK[N-1:0]) == CAUSE_MASK[N-1:0])); // R4
    AST_RESET_CLEAR: assert property (@(posedge clk)
        $past(rst) |-> ((flags == '0) && (enables == '0) && (cfg_num == '0)));  // R8
    AST_CONFIG_SETS: assert property (@(posedge clk) disable iff (rst)
        ev_config |=> reg_rdata[FLG_CONFIG] || !(reg_sel && !reg_wr && !reg_addr)); // R1

endmodule

// File: tb/test_usbev_status_top.sv
module test_usbev_status_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  ev = '0;       // [5]susp [4]sof [3]busrst [2]wakeup [1]setup [0]config
    logic        cfg_v = 1'b0;
    logic        sel = 1'b0, wr = 1'b0, rmw = 1'b0, addr = 1'b0;
    logic [15:0] wd = '0;
    logic [15:0] rdata;
    logic        irq;
    logic [0:0]  cfg_num;

    int checks = 0, failures = 0;
    bit finished = 0;

    // behavioural reference state
    bit m_flag[6];
    bit m_en[6];
    bit m_cfg;

    always #4 clk = ~clk;   // 125 MHz

    usbev_status_top i_usbev_status_top (
        .clk(clk), .rst(rst),
        .ev_suspend(ev[5]), .ev_sof(ev[4]), .ev_bus_reset(ev[3]),
        .ev_wakeup(ev[2]), .ev_setup(ev[1]), .ev_config(ev[0]),
        .ev_config_val(cfg_v),
        .reg_sel(sel), .reg_wr(wr), .reg_rmw(rmw), .reg_addr(addr),
        .reg_wdata(wd), .reg_rdata(rdata), .irq(irq), .cfg_num(cfg_num)
    );

    function automatic bit m_is_cause(int k);
        return k != 1;
    endfunction

    function automatic logic [15:0] m_read();
        logic [15:0] v = '0;
        if (!addr) begin
            for (int k = 0; k < 6; k++)
                v[k] = m_flag[k] | (rmw & m_is_cause(k));
        end else begin
            for (int k = 0; k < 6; k++)
                v[k] = m_en[k];
            v[8] = m_cfg;
        end
        return v;
    endfunction

    function automatic bit m_irq();
        bit r = 0;
        for (int k = 0; k < 6; k++)
            if (m_is_cause(k) && m_flag[k] && m_en[k]) r = 1;
        return r;
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive, check read data before the edge, update model, check outputs after
    task automatic cyc(logic [5:0] e, logic cv, logic s, logic w, logic r, logic a,
                       logic [15:0] d, string tag);
        @(negedge clk);
        ev = e; cfg_v = cv; sel = s; wr = w; rmw = r; addr = a; wd = d;
        #1;
        if (!rst) begin
            if (s && !w) check(tag, rdata, m_read());
            else         check({tag, " idle-rdata"}, rdata, 16'h0);
        end
        @(posedge clk);
        if (rst) begin
            for (int k = 0; k < 6; k++) begin m_flag[k] = 0; m_en[k] = 0; end
            m_cfg = 0;
        end else begin
            if (s && w && !a)
                for (int k = 0; k < 6; k++) if (!d[k]) m_flag[k] = 0;
            if (s && w && a)
                for (int k = 0; k < 6; k++) m_en[k] = m_is_cause(k) ? d[k] : 1'b0;
            for (int k = 0; k < 6; k++) if (e[k]) m_flag[k] = 1;
            if (e[0]) m_cfg = cv;
        end
        #1;
        if (!rst) begin
            check("R6 irq", {15'h0, irq}, {15'h0, m_irq()});
            check("R7 cfg_num", {15'h0, cfg_num}, {15'h0, m_cfg});
        end
    endtask

    task automatic idle(); cyc('0, 0, 0, 0, 0, 0, '0, "idle"); endtask
    task automatic rd(logic a, logic r, string tag); cyc('0, 0, 1, 0, r, a, '0, tag); endtask
    task automatic wrt(logic a, logic [15:0] d, string tag); cyc('0, 0, 1, 1, 0, a, d, tag); endtask
    task automatic pulse(logic [5:0] e, logic cv, string tag); cyc(e, cv, 0, 0, 0, 0, '0, tag); endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 3; i++) idle();
        rst = 1'b0;
        // R8 reset state
        rd(0, 0, "R8 status after reset");
        rd(1, 0, "R8 enable after reset");
        check("R8 irq after reset", {15'h0, irq}, 16'h0);

        // R1 each event alone lands on its own bit
        for (int k = 0; k < 6; k++) begin
            pulse(6'b1 << k, 1'b0, "R1 pulse");
            rd(0, 0, "R1 flag position");
            wrt(0, 16'h0, "R2 clear all");
            rd(0, 0, "R2 cleared");
        end

        // R2 writing 1 never sets
        wrt(0, 16'hFFFF, "R2 write ones");
        rd(0, 0, "R2 ones did not set");
        // R2 mixed clear
        pulse(6'b111111, 1'b1, "R1 all events");
        wrt(0, 16'b101010, "R2 mixed clear");
        rd(0, 0, "R2 mixed result");

        // R3 event with clearing write on same bit
        cyc(6'b010001, 1'b0, 1, 1, 0, 0, 16'h0, "R3 collide");
        rd(0, 0, "R3 event wins");

        // R4 plain vs rmw read, then write back
        wrt(0, 16'h0, "R2 clear");
        pulse(6'b000010, 1'b0, "R1 setup");
        rd(0, 0, "R4 plain read");
        rd(0, 1, "R4 rmw read");
        wrt(0, 16'h0002, "R4 setup-only write-back");
        wrt(0, 16'h0, "R2 clear");
        rd(0, 1, "R4 rmw read setup clear");
        pulse(6'b100100, 1'b0, "R1 susp wake");
        wrt(0, 16'h003D, "R4 rmw write-back");
        rd(0, 0, "R4 flags unchanged");

        // R5 enable register
        wrt(1, 16'hFFFF, "R5 enable all");
        rd(1, 0, "R5 enable readback");
        wrt(1, 16'h0000, "R5 enable none");
        rd(1, 0, "R5 enable zero");

        // R6 one cause at a time
        wrt(0, 16'h0, "R2 clear");
        for (int k = 0; k < 6; k++) begin
            wrt(1, 16'h1 << k, "R6 single enable");
            pulse(6'b1 << k, 1'b1, "R6 single cause");
            wrt(0, 16'h0, "R6 clear");
            pulse(6'b111111 & ~(6'b1 << k), 1'b0, "R6 other causes masked");
            wrt(0, 16'h0, "R6 clear");
        end
        wrt(1, 16'h003F, "R6 all enables");
        pulse(6'b000010, 1'b0, "R6 setup no irq");
        rd(0, 0, "R6 setup flagged");

        // R7 configuration value capture
        pulse(6'b000001, 1'b1, "R7 capture 1");
        rd(1, 0, "R7 readback 1");
        wrt(1, 16'h0000, "R7 write ignored");
        rd(1, 0, "R7 still 1");
        pulse(6'b000001, 1'b0, "R7 capture 0");
        rd(1, 0, "R7 readback 0");

        // R8 reset mid-run
        pulse(6'b111111, 1'b1, "R1 all");
        wrt(1, 16'h003F, "R5 all");
        rst = 1'b1;
        idle();
        rst = 1'b0;
        rd(0, 0, "R8 status after second reset");
        rd(1, 0, "R8 enable after second reset");

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule